// File: doc/BRIEF.md
# Four-Channel Serial Converter Scan Sequencer

This block is the host side of a link to a four-input, 8-bit successive-approximation converter that talks over a four-wire serial port: a bit clock, an active-low select, a command line into the converter and a data line out of it. From a fast system clock the sequencer makes the bit clock and frames conversions of sixteen bit-clock periods each. In every conversion it shifts out a command byte naming the channel for the *following* conversion, and it shifts in the 8-bit result of the current one.

The converter always converts the channel named one conversion earlier. The sequencer therefore tracks the channel the converter has pending. It tags every result with the channel that was really sampled and names the next enabled channel one step ahead. A four-bit enable mask picks the channels, which are visited in rising order with wrap-around. Results leave on a valid/ready stream as an 8-bit value with a 2-bit channel tag. A result is discarded when its channel was not enabled at the start of that conversion, as can happen with the first conversion after reset. A level-sensitive run input and a burst length set how many conversions share one select-low frame. When the single output slot is still occupied, the select line goes high between conversions, so no result is ever overwritten.

Top module: `adc_scan_seq`

## Requirements
- R1: The select line falls only while the bit clock is high. The bit clock rests high whenever select is high. The first falling bit-clock edge comes one half period after select falls.
- R2: Every frame holds a whole multiple of 16 rising bit-clock edges. Select rises one half period after the 16th rising edge of the last conversion.
- R3: Each bit-clock phase lasts `div_sel` system cycles, clamped to the range 40..156 with the default parameters (250 MHz system clock, 0.8 to 3.2 MHz bit clock). Values below the range give 40 and values above it give 156.
- R4: The command byte goes out most significant bit first, one bit per falling bit-clock edge on edges 1 to 8, and the line changes only on falling edges. The channel number sits in bits 4:3 and all other bits are 0.
- R5: The line from the converter is sampled on rising edges 5 to 12 of each conversion. The first sampled bit becomes result bit 7 and the last becomes bit 0.
- R6: The channel sent in a conversion is the first enabled channel found by counting upward, with wrap, from the channel being converted. If that channel is the only one enabled, it is sent again.
- R7: After reset the converter is assumed to hold channel 0. Each result is tagged with the channel sent in the preceding conversion. A result whose channel was not enabled at the start of its conversion is not emitted.
- R8: A result stays on the stream, unchanged, while valid is high and ready is low. A new frame never starts while a result is waiting. A frame ends after the current conversion if the waiting result has not been taken by its 16th rising edge.
- R9: One frame carries at most `burst_len` conversions, and a value of 0 counts as 1. When `run` goes low, the conversion in progress completes, select rises, and no new frame starts.
- R10: With an all-zero enable mask no frame starts. Once a channel is enabled, scanning begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level: keep scanning while high |
| scan_mask | input | 4 | Channel enable bits, bit n enables channel n |
| burst_len | input | 8 | Conversions per select-low frame (0 treated as 1) |
| div_sel | input | 8 | Bit-clock half period in system cycles, before clamping |
| adc_sclk | output | 1 | Bit clock to the converter |
| adc_cs_n | output | 1 | Active-low select to the converter |
| adc_din | output | 1 | Command bits to the converter |
| adc_dout | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result beat available |
| res_ready | input | 1 | Consumer accepts the beat |
| res_data | output | 8 | Converted value |
| res_chan | output | 2 | Channel the value was sampled from |

## Verification
A wrong pending-channel register does not break any framing. It shows up at the stream as a tag that disagrees with the channel encoded in the returned value, starting with the first beat after the fault. A converter model in the bench returns values that carry both their channel and a running conversion index, so a skipped, repeated or mislabelled conversion is caught on the very next beat. An off-by-one in the edge counter moves the sample window, so the result bits come back shifted, and a frame would end with a count of rising edges that is not a multiple of 16. Divider faults are caught by timing the bit-clock phases directly.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int CHANS     = 4;
    localparam int CH_W      = $clog2(CHANS);
    localparam int RES_W     = 8;
    localparam int CTRL_W    = 8;
    localparam int ADDR_LSB  = 3;                  // channel field position in the command byte
    localparam int EDGES     = 16;                 // bit-clock periods per conversion
    localparam int POS_W     = $clog2(2 * EDGES);  // half-period position within a conversion
    localparam int EDGE_W    = POS_W - 1;
    localparam int FIRST_SMP = 4;                  // zero-based rising edge of result MSB
    localparam int LAST_SMP  = FIRST_SMP + RES_W - 1;

    typedef logic [CH_W-1:0]  chan_t;
    typedef logic [CHANS-1:0] mask_t;

    typedef struct packed {
        chan_t              chan;
        logic [RES_W-1:0]   data;
    } beat_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_SHIFT,
        SQ_HOLD,
        SQ_GAP
    } sq_state_t;

    // first enabled channel above cur, wrapping; cur itself when alone
    function automatic chan_t next_chan(mask_t m, chan_t cur);
        chan_t pick;
        logic  found;
        pick  = cur;
        found = 1'b0;
        for (int k = 1; k <= CHANS; k++) begin
            chan_t c;
            c = cur + chan_t'(k);
            if (!found && m[c]) begin
                pick  = c;
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_word(chan_t ch);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[ADDR_LSB +: CH_W] = ch;
        return w;
    endfunction

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] half,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || cnt == '0) begin
            cnt <= half - W'(1);
        end else begin
            cnt <= cnt - W'(1);
        end
    end

    assign tick = (cnt == '0) && !restart;
endmodule

// File: rtl/adc_scan_shift.sv
module adc_scan_shift
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] word,
    input  logic              advance,
    input  logic              sample,
    input  logic              dout,
    output logic              din,
    output logic [RES_W-1:0]  cap_word
);
    logic [CTRL_W-1:0] tx;
    logic [RES_W-1:0]  rx;

    assign cap_word = {rx[RES_W-2:0], dout};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx  <= '0;
            rx  <= '0;
            din <= 1'b0;
        end else begin
            if (load) begin
                din <= word[CTRL_W-1];
                tx  <= {word[CTRL_W-2:0], 1'b0};
            end else if (advance) begin
                din <= tx[CTRL_W-1];
                tx  <= {tx[CTRL_W-2:0], 1'b0};
            end
            if (sample) begin
                rx <= cap_word;
            end
        end
    end
endmodule

// File: rtl/adc_scan_outbuf.sv
module adc_scan_outbuf
    import adc_scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  beat_t push_beat,
    input  logic  ready,
    output logic  valid,
    output beat_t beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            beat  <= '0;
        end else if (push) begin
            valid <= 1'b1;
            beat  <= push_beat;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int SYS_KHZ      = 250000,
    parameter int SCLK_MAX_KHZ = 3200,
    parameter int SCLK_MIN_KHZ = 800,
    parameter int DIV_W        = 8,
    parameter int BURST_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [CHANS-1:0]   scan_mask,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [DIV_W-1:0]   div_sel,
    output logic               adc_sclk,
    output logic               adc_cs_n,
    output logic               adc_din,
    input  logic               adc_dout,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [RES_W-1:0]   res_data,
    output logic [CH_W-1:0]    res_chan
);
    localparam int HALF_LO = (SYS_KHZ + 2 * SCLK_MAX_KHZ - 1) / (2 * SCLK_MAX_KHZ);
    localparam int HALF_HI = SYS_KHZ / (2 * SCLK_MIN_KHZ);

    logic [DIV_W-1:0] half_lo, half_hi, half_new, half_q, half_use;
    assign half_lo  = DIV_W'(HALF_LO);
    assign half_hi  = DIV_W'(HALF_HI);
    assign half_new = (div_sel < half_lo) ? half_lo :
                      (div_sel > half_hi) ? half_hi : div_sel;

    sq_state_t          st;
    logic [POS_W-1:0]   pos;
    logic [BURST_W-1:0] conv_cnt, burst_q;
    chan_t              pend, conv, nxt;
    logic               keep;
    logic               tick, go, more, buf_full;
    logic               start_conv, rise_ev, fall_ev, smp, push;
    logic [EDGE_W-1:0]  edge_idx;
    logic               low_phase, last_edge;
    logic [RES_W-1:0]   cap_word;
    beat_t              out_beat;

    assign edge_idx  = pos[POS_W-1:1];
    assign low_phase = !pos[0];
    assign last_edge = (edge_idx == EDGE_W'(EDGES - 1));
    assign nxt       = next_chan(scan_mask, pend);
    assign go        = run && (|scan_mask) && !buf_full;
    assign more      = go && (conv_cnt < burst_q);
    assign half_use  = (st == SQ_IDLE) ? half_new : half_q;

    assign start_conv = tick && ((st == SQ_SETUP) ||
                                 (st == SQ_SHIFT && !low_phase && last_edge));
    assign rise_ev    = tick && (st == SQ_SHIFT) && low_phase;
    assign fall_ev    = tick && (st == SQ_SHIFT) && !low_phase && !last_edge;
    assign smp        = rise_ev && (edge_idx >= EDGE_W'(FIRST_SMP)) &&
                                   (edge_idx <= EDGE_W'(LAST_SMP));
    assign push       = rise_ev && (edge_idx == EDGE_W'(LAST_SMP)) && keep;

    adc_scan_tick #(.W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart ((st == SQ_IDLE) && go),
        .half    (half_use),
        .tick    (tick)
    );

    adc_scan_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start_conv),
        .word     (ctrl_word(nxt)),
        .advance  (fall_ev),
        .sample   (smp),
        .dout     (adc_dout),
        .din      (adc_din),
        .cap_word (cap_word)
    );

    adc_scan_outbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_beat ('{chan: conv, data: cap_word}),
        .ready     (res_ready),
        .valid     (buf_full),
        .beat      (out_beat)
    );

    assign res_valid = buf_full;
    assign res_data  = out_beat.data;
    assign res_chan  = out_beat.chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            adc_cs_n <= 1'b1;
            adc_sclk <= 1'b1;
            pos      <= '0;
            conv_cnt <= '0;
            burst_q  <= BURST_W'(1);
            half_q   <= half_lo;
            pend     <= '0;
            conv     <= '0;
            keep     <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (go) begin
                    adc_cs_n <= 1'b0;
                    half_q   <= half_new;
                    burst_q  <= (burst_len == '0) ? BURST_W'(1) : burst_len;
                    conv_cnt <= '0;
                    st       <= SQ_SETUP;
                end
                SQ_SHIFT: begin
                    if (rise_ev) begin
                        adc_sclk <= 1'b1;
                        if (last_edge && !more) st  <= SQ_HOLD;
                        else                    pos <= pos + POS_W'(1);
                    end
                    if (fall_ev) begin
                        adc_sclk <= 1'b0;
                        pos      <= pos + POS_W'(1);
                    end
                end
                SQ_HOLD: if (tick) begin
                    adc_cs_n <= 1'b1;
                    st       <= SQ_GAP;
                end
                SQ_GAP: if (tick) st <= SQ_IDLE;
                default: ;
            endcase
            if (start_conv) begin
                adc_sclk <= 1'b0;
                pos      <= '0;
                conv     <= pend;
                keep     <= scan_mask[pend];
                pend     <= nxt;
                conv_cnt <= conv_cnt + BURST_W'(1);
                st       <= SQ_SHIFT;
            end
        end
    end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             adc_sclk,
    input logic             adc_cs_n,
    input logic             adc_din,
    input logic [CHANS-1:0] scan_mask,
    input logic             res_valid,
    input logic             res_ready,
    input logic [RES_W-1:0] res_data,
    input logic [CH_W-1:0]  res_chan,
    input logic [DIV_W-1:0] half_lo
);
    logic             sclk_q;
    logic [DIV_W:0]   run_len;
    logic [3:0]       rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b1;
            run_len  <= '0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= adc_sclk;
            if (adc_sclk != sclk_q)  run_len <= (DIV_W+1)'(1);
            else if (~&run_len)      run_len <= run_len + (DIV_W+1)'(1);
            if (adc_cs_n)                    rise_cnt <= '0;
            else if (adc_sclk && !sclk_q)    rise_cnt <= rise_cnt + 4'd1;
        end
    end

    p_cs_fall_sclk_high_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> adc_sclk);
    p_sclk_rests_high_r1: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);
    p_frame_whole_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (rise_cnt == 4'd0));
    p_half_min_r3: assert property (@(posedge clk) disable iff (rst)
        (adc_sclk != sclk_q) |-> (run_len >= {1'b0, half_lo}));
    p_din_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (adc_din != $past(adc_din)) |-> $fell(adc_sclk));
    p_beat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));
    p_no_frame_when_full_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> !$past(res_valid));
    p_no_frame_empty_mask_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> ($past(scan_mask) != '0));
endmodule

bind adc_scan_seq adc_scan_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_sclk  (adc_sclk),
    .adc_cs_n  (adc_cs_n),
    .adc_din   (adc_din),
    .scan_mask (scan_mask),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .half_lo   (half_lo)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [3:0] scan_mask = 4'd0;
    logic [7:0] burst_len = 8'd0;
    logic [7:0] div_sel = 8'd0;
    logic       adc_dout = 1'b0;
    logic       res_ready = 1'b0;
    logic       adc_sclk, adc_cs_n, adc_din, res_valid;
    logic [7:0] res_data;
    logic [1:0] res_chan;

    always #2 clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst(rst), .run(run), .scan_mask(scan_mask),
        .burst_len(burst_len), .div_sel(div_sel),
        .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n), .adc_din(adc_din),
        .adc_dout(adc_dout), .res_valid(res_valid), .res_ready(res_ready),
        .res_data(res_data), .res_chan(res_chan)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(negedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter model
    bit         emu_on = 0;
    int         emu_pend, emu_conv, emu_fall, emu_rise, emu_seq;
    logic [7:0] emu_val, emu_ctrl;
    int         frames, frame_rises;
    int         frame_convs[64];

    always @(negedge adc_cs_n) if (emu_on) begin
        chk(adc_sclk == 1'b1, "R1", "sclk at select fall", int'(adc_sclk), 1);
        frame_rises = 0;
        emu_fall = 0;
        emu_rise = 0;
    end

    always @(negedge adc_sclk) if (emu_on && !adc_cs_n) begin
        emu_fall = emu_fall % 16 + 1;
        if (emu_fall == 1) begin
            emu_conv = emu_pend;
            emu_seq++;
            emu_val = {emu_conv[1:0], emu_seq[5:0]};
        end
        adc_dout = (emu_fall >= 5 && emu_fall <= 12) ? emu_val[12 - emu_fall] : 1'b0;
    end

    always @(posedge adc_sclk) if (emu_on && !adc_cs_n) begin
        emu_rise = emu_rise % 16 + 1;
        frame_rises++;
        if (emu_rise <= 8) emu_ctrl = {emu_ctrl[6:0], adc_din};
        if (emu_rise == 8) begin
            chk((emu_ctrl & 8'b1110_0111) == 8'd0, "R4", "command spare bits",
                int'(emu_ctrl), int'(emu_ctrl & 8'b0001_1000));
            emu_pend = int'(emu_ctrl[4:3]);
        end
    end

    always @(posedge adc_cs_n) if (emu_on) begin
        chk(frame_rises % 16 == 0, "R2", "rising edges in frame", frame_rises, 16 * (frame_rises / 16));
        if (frames < 64) frame_convs[frames] = frame_rises / 16;
        frames++;
    end

    // stream capture
    int         got_n = 0;
    int         got_ch[64];
    logic [7:0] got_d[64];
    always @(negedge clk) if (res_valid && res_ready && got_n < 64) begin
        got_ch[got_n] = int'(res_chan);
        got_d[got_n]  = res_data;
        got_n++;
    end

    function automatic int bnext(logic [3:0] m, int c);
        int pick = c;
        bit found = 0;
        for (int k = 1; k <= 4; k++) begin
            int t = (c + k) % 4;
            if (!found && m[t]) begin
                pick = t;
                found = 1;
            end
        end
        return pick;
    endfunction

    // R6/R7/R5 reference: channel order from reset, value = {chan, conversion index}
    task automatic expect_seq(input logic [3:0] m, input int n);
        int pend = 0;
        int idx = 0;
        int b = 0;
        while (b < n && idx < 64) begin
            int c = pend;
            idx++;
            pend = bnext(m, c);
            if (m[c]) begin
                chk(got_ch[b] == c, "R7", "beat tag", got_ch[b], c);
                chk(got_d[b] == {c[1:0], idx[5:0]}, "R5", "beat value",
                    int'(got_d[b]), int'({c[1:0], idx[5:0]}));
                chk(got_ch[b] == int'(got_d[b][7:6]), "R6", "tag vs sampled channel",
                    got_ch[b], int'(got_d[b][7:6]));
                b++;
            end
        end
    endtask

    task automatic do_reset();
        run = 1'b0;
        emu_on = 0;
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        emu_pend = 0; emu_seq = 0; emu_fall = 0; emu_rise = 0;
        frames = 0; frame_rises = 0; got_n = 0;
        rst = 1'b0;
        emu_on = 1;
    endtask

    task automatic stop_and_idle();
        @(posedge clk); #1;
        run = 1'b0;
        wait (adc_cs_n == 1'b1);
        repeat (400) @(negedge clk);
    endtask

    task automatic wait_beats(input int n);
        while (got_n < n) @(negedge clk);
    endtask

    task automatic measure_half(output int h);
        int t0;
        @(negedge adc_sclk); t0 = cyc;
        @(posedge adc_sclk); h = cyc - t0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1", "select after reset", int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b1, "R1", "sclk after reset", int'(adc_sclk), 1);
        chk(res_valid == 1'b0, "R8", "valid after reset", int'(res_valid), 0);
    endtask

    task automatic t_rotate();
        int h;
        do_reset();
        scan_mask = 4'b1010; burst_len = 8'd4; div_sel = 8'd0; res_ready = 1'b1;
        run = 1'b1;
        measure_half(h);
        chk(h == 40, "R3", "half period below range", h, 40);
        wait_beats(6);
        stop_and_idle();
        expect_seq(4'b1010, 6);
        chk(frame_convs[0] == 4, "R9", "conversions in first frame", frame_convs[0], 4);
    endtask

    task automatic t_period();
        int h;
        do_reset();
        scan_mask = 4'b0001; burst_len = 8'd1; res_ready = 1'b1;
        div_sel = 8'd200; run = 1'b1;
        measure_half(h);
        chk(h == 156, "R3", "half period above range", h, 156);
        stop_and_idle();
        div_sel = 8'd77; run = 1'b1;
        measure_half(h);
        chk(h == 77, "R3", "half period in range", h, 77);
        stop_and_idle();
    endtask

    task automatic t_backpressure();
        logic [7:0] held;
        do_reset();
        scan_mask = 4'b1111; burst_len = 8'd8; div_sel = 8'd40; res_ready = 1'b0;
        run = 1'b1;
        repeat (4000) @(negedge clk);
        chk(frames == 1, "R8", "frames while stream stalled", frames, 1);
        chk(frame_convs[0] == 1, "R8", "conversions before stall", frame_convs[0], 1);
        chk(adc_cs_n == 1'b1, "R8", "select high while full", int'(adc_cs_n), 1);
        chk(res_valid == 1'b1, "R8", "beat waiting", int'(res_valid), 1);
        held = res_data;
        repeat (200) @(negedge clk);
        chk(res_data == held && res_chan == 2'd0, "R8", "held beat value",
            int'(res_data), int'(held));
        chk(held == 8'h01, "R7", "first beat after reset", int'(held), 1);
        @(posedge clk); #1;
        res_ready = 1'b1;
        wait_beats(5);
        stop_and_idle();
        expect_seq(4'b1111, 5);
    endtask

    task automatic t_burst_stop();
        int f;
        do_reset();
        scan_mask = 4'b0011; burst_len = 8'd2; div_sel = 8'd40; res_ready = 1'b1;
        run = 1'b1;
        while (frames < 3) @(negedge clk);
        stop_and_idle();
        f = frames;
        for (int i = 0; i < 3; i++)
            chk(frame_convs[i] == 2, "R9", "conversions per frame", frame_convs[i], 2);
        repeat (3000) @(negedge clk);
        chk(frames == f, "R9", "frames after run low", frames, f);
        chk(adc_cs_n == 1'b1, "R9", "select after run low", int'(adc_cs_n), 1);
        expect_seq(4'b0011, 4);
    endtask

    task automatic t_single();
        do_reset();
        scan_mask = 4'b0100; burst_len = 8'd0; div_sel = 8'd40; res_ready = 1'b1;
        run = 1'b1;
        wait_beats(3);
        stop_and_idle();
        expect_seq(4'b0100, 3);
        chk(frame_convs[0] == 1, "R9", "zero burst length", frame_convs[0], 1);
        chk(got_d[0][5:0] == 6'd2, "R7", "unenabled first result dropped",
            int'(got_d[0][5:0]), 2);
    endtask

    task automatic t_nomask();
        do_reset();
        scan_mask = 4'b0000; burst_len = 8'd1; div_sel = 8'd40; res_ready = 1'b1;
        run = 1'b1;
        repeat (2000) @(negedge clk);
        chk(frames == 0, "R10", "frames with empty mask", frames, 0);
        chk(adc_cs_n == 1'b1, "R10", "select with empty mask", int'(adc_cs_n), 1);
        @(posedge clk); #1;
        scan_mask = 4'b0001;
        wait_beats(1);
        stop_and_idle();
        chk(got_ch[0] == 0 && got_d[0] == 8'h01, "R10", "scan after enabling",
            int'(got_d[0]), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rotate();
        t_period();
        t_backpressure();
        t_burst_stop();
        t_single();
        t_nomask();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule